// File: doc/BRIEF.md
# Floating-Point Register Specifier Decoder

This block sits between instruction decode and a floating-point register file made of 32-bit words. For each operand slot (first source, second source, destination) it takes the 5-bit register field from the instruction word and the operand's size. The size code is 0 for an unused slot, 1 for single, 2 for double and 3 for quad. From these it produces a 6-bit physical word index and a valid strobe. The physical file has two banks of 32 words each. Index bit 5 selects the bank, so wide operands can reach the upper bank.

Each request is also screened in two ways. First, it is dropped when the fault class recorded by the trapping logic does not match the class the caller expects for this operation. Second, it fails with the invalid-register fault code when a quad operand names a misaligned register. The block keeps one enable flag per bank. A source in a bank that is not enabled is flagged to read as zero. A destination in a bank that is not enabled raises a one-cycle wipe strobe for that bank and turns the bank's flag on. All results are registered and appear on the clock edge that samples the request.

Top module: `fpRegDecode`

## Requirements
- R1: A single operand (size 1) yields an index equal to its 5-bit field, with index bit 5 at 0.
- R2: A double or quad operand (size 2 or 3) yields the index {field[0], field[4:1], 0}, so field bit 0 becomes index bit 5 and index bit 0 is always 0.
- R3: The destination field is instruction bits 29:25, the first source field is bits 18:14 and the second source field is bits 4:0; no other instruction bit affects any output.
- R4: An operand of size 0 has its valid low and its index 0, and an unused destination never raises a wipe strobe.
- R5: When any quad operand has field bit 1 set, the request raises the error strobe and sets the fault code output to 6. In that case no valid, zero flag or wipe strobe is raised and the bank flags are unchanged.
- R6: When the stored fault type differs from the expected fault type, the request raises the reject strobe and copies the stored fault type to the fault code output. In that case nothing else is raised and the bank flags are unchanged. This check takes priority over R5.
- R7: An accepted request raises the done strobe and clears the fault code output to 0.
- R8: A valid source whose index has bit 5 equal to b raises its zero flag exactly when bank b's enable flag is off.
- R9: A valid destination in bank b (index bit 5) whose enable flag is off raises bank b's wipe strobe for one cycle, and the flag is on from that cycle onward. A destination in a bank that is already enabled raises no wipe strobe.
- R10: After reset both bank flags are off, every strobe is low and the fault code output is 0.
- R11: Outputs update on the first rising edge that samples the request. In a cycle with no request every strobe is low, every index is 0 and the fault code output holds its value.
- R12: Source zero flags use the bank flags as they were before the same request's destination enables a bank.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Request present this cycle |
| instr | input | 32 | Instruction word |
| rs1Size | input | 2 | First source size (0 none, 1 single, 2 double, 3 quad) |
| rs2Size | input | 2 | Second source size |
| rdSize | input | 2 | Destination size |
| expFault | input | 3 | Fault type expected for this operation class |
| storedFault | input | 3 | Fault type currently recorded |
| rs1Idx | output | 6 | First source physical index |
| rs2Idx | output | 6 | Second source physical index |
| rdIdx | output | 6 | Destination physical index |
| rs1Vld | output | 1 | First source valid |
| rs2Vld | output | 1 | Second source valid |
| rdVld | output | 1 | Destination valid |
| rs1Zero | output | 1 | First source reads as zero |
| rs2Zero | output | 1 | Second source reads as zero |
| opDone | output | 1 | Request accepted |
| regErr | output | 1 | Invalid-register error |
| typeReject | output | 1 | Fault-type mismatch reject |
| faultCode | output | 3 | Fault code resulting from the last request |
| wipeLo | output | 1 | Clear lower bank now |
| wipeHi | output | 1 | Clear upper bank now |
| bankLoOn | output | 1 | Lower bank enabled |
| bankHiOn | output | 1 | Upper bank enabled |

## Verification
Two events can land in the same cycle. A source can be flagged as zero while the destination of that same request wipes and enables the bank the source lives in. The bench provokes this with a first single-precision request after reset whose sources and destination all sit in the lower bank. It then expects both zero flags and the lower wipe strobe in the same output cycle, with the bank flag on afterwards. A later request into the now-enabled bank must show neither effect. The bench also sends requests that carry both a type mismatch and a misaligned quad. It expects the reject to win and the bank flags to stay unchanged.

// File: rtl/fpRegDecode_pkg.sv
package fpRegDecode_pkg;

  typedef enum logic [1:0] {
    SZ_NONE   = 2'd0,
    SZ_SINGLE = 2'd1,
    SZ_DOUBLE = 2'd2,
    SZ_QUAD   = 2'd3
  } opSize_e;

  // operand slot numbering used across the block
  localparam int OP_RS1 = 0;
  localparam int OP_RS2 = 1;
  localparam int OP_RD  = 2;
  localparam int OP_CNT = 3;

  typedef struct packed {
    logic accept;
    logic illegal;
    logic reject;
  } ctrlStrobe_t;

endpackage

// File: rtl/fpRegDecode_opMap.sv
module fpRegDecode_opMap
  import fpRegDecode_pkg::*;
#(
  parameter int FIELD_W = 5,
  localparam int IDX_W  = FIELD_W + 1
) (
  input  logic [FIELD_W-1:0] field,
  input  logic [1:0]         size,
  output logic [IDX_W-1:0]   idx,
  output logic               used,
  output logic               illegal
);

  opSize_e sizeE;
  assign sizeE = opSize_e'(size);

  always_comb begin
    unique case (sizeE)
      SZ_NONE:   idx = '0;
      SZ_SINGLE: idx = {1'b0, field};
      default:   idx = {field[0], field[FIELD_W-1:1], 1'b0};
    endcase
  end

  assign used    = (sizeE != SZ_NONE);
  assign illegal = (sizeE == SZ_QUAD) && field[1];

  // quad index must be aligned to four words when legal
  always_comb begin
    if (sizeE == SZ_QUAD && !illegal) begin
      p_quad_aligned_r2: assert (idx[1:0] == 2'b00);
    end
  end

endmodule

// File: rtl/fpRegDecode_ctrl.sv
module fpRegDecode_ctrl
  import fpRegDecode_pkg::*;
#(
  parameter int FAULT_W = 3
) (
  input  logic               reqValid,
  input  logic [FAULT_W-1:0] expFault,
  input  logic [FAULT_W-1:0] storedFault,
  input  logic [OP_CNT-1:0]  opIllegal,
  output ctrlStrobe_t        strobe
);

  logic mismatch;
  logic anyIllegal;

  assign mismatch   = (expFault != storedFault);
  assign anyIllegal = |opIllegal;

  // type check wins over register check; register check covers all slots at once
  always_comb begin
    strobe.reject  = reqValid && mismatch;
    strobe.illegal = reqValid && !mismatch && anyIllegal;
    strobe.accept  = reqValid && !mismatch && !anyIllegal;
  end

endmodule

// File: rtl/fpRegDecode_dp.sv
module fpRegDecode_dp
  import fpRegDecode_pkg::*;
#(
  parameter int IDX_W        = 6,
  parameter int FAULT_W      = 3,
  parameter int ILLEGAL_CODE = 6,
  localparam int BANK_BIT    = IDX_W - 1,
  localparam int SRC_CNT     = 2
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  ctrlStrobe_t                   strobe,
  input  logic [OP_CNT-1:0][IDX_W-1:0]  idxIn,
  input  logic [OP_CNT-1:0]             usedIn,
  input  logic [FAULT_W-1:0]            storedFault,
  output logic [OP_CNT-1:0][IDX_W-1:0]  idxQ,
  output logic [OP_CNT-1:0]             vldQ,
  output logic [SRC_CNT-1:0]            zeroQ,
  output logic [1:0]                    wipeQ,
  output logic [1:0]                    bankOnQ,
  output logic                          doneQ,
  output logic                          errQ,
  output logic                          rejQ,
  output logic [FAULT_W-1:0]            faultQ
);

  logic [OP_CNT-1:0]            vldNext;
  logic [OP_CNT-1:0][IDX_W-1:0] idxNext;
  logic [SRC_CNT-1:0]           zeroNext;
  logic [1:0]                   wipeNext;
  logic                         rdBank;

  assign vldNext = strobe.accept ? usedIn : '0;
  assign rdBank  = idxIn[OP_RD][BANK_BIT];

  for (genvar g = 0; g < OP_CNT; g++) begin : g_idx
    assign idxNext[g] = vldNext[g] ? idxIn[g] : '0;
  end

  // sources see the bank flags before this request's destination update
  for (genvar s = 0; s < SRC_CNT; s++) begin : g_zero
    assign zeroNext[s] = vldNext[s] && !bankOnQ[idxIn[s][BANK_BIT]];
  end

  for (genvar b = 0; b < 2; b++) begin : g_wipe
    assign wipeNext[b] = vldNext[OP_RD] && (rdBank == 1'(b)) && !bankOnQ[b];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idxQ    <= '0;
      vldQ    <= '0;
      zeroQ   <= '0;
      wipeQ   <= '0;
      bankOnQ <= '0;
      doneQ   <= 1'b0;
      errQ    <= 1'b0;
      rejQ    <= 1'b0;
      faultQ  <= '0;
    end else begin
      idxQ    <= idxNext;
      vldQ    <= vldNext;
      zeroQ   <= zeroNext;
      wipeQ   <= wipeNext;
      bankOnQ <= bankOnQ | wipeNext;
      doneQ   <= strobe.accept;
      errQ    <= strobe.illegal;
      rejQ    <= strobe.reject;
      if (strobe.accept)       faultQ <= '0;
      else if (strobe.illegal) faultQ <= FAULT_W'(ILLEGAL_CODE);
      else if (strobe.reject)  faultQ <= storedFault;
    end
  end

  p_err_blocks_r5: assert property (@(posedge clk) disable iff (!rst_n)
    errQ |-> (vldQ == '0 && wipeQ == '0 && zeroQ == '0 && faultQ == FAULT_W'(ILLEGAL_CODE)));

  p_err_banks_r5: assert property (@(posedge clk) disable iff (!rst_n)
    errQ |-> $stable(bankOnQ));

  p_reject_banks_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rejQ |-> ($stable(bankOnQ) && vldQ == '0 && !errQ));

  p_wipe_rise_lo_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wipeQ[0] |-> $rose(bankOnQ[0]));

  p_wipe_rise_hi_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wipeQ[1] |-> $rose(bankOnQ[1]));

  p_bank_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    bankOnQ[0] |=> bankOnQ[0]);

  p_one_outcome_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({doneQ, errQ, rejQ}));

endmodule

// File: rtl/fpRegDecode.sv
module fpRegDecode
  import fpRegDecode_pkg::*;
#(
  parameter int INSTR_W      = 32,
  parameter int FIELD_W      = 5,
  parameter int RS1_LSB      = 14,
  parameter int RS2_LSB      = 0,
  parameter int RD_LSB       = 25,
  parameter int FAULT_W      = 3,
  parameter int ILLEGAL_CODE = 6,
  localparam int IDX_W       = FIELD_W + 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reqValid,
  input  logic [INSTR_W-1:0] instr,
  input  logic [1:0]         rs1Size,
  input  logic [1:0]         rs2Size,
  input  logic [1:0]         rdSize,
  input  logic [FAULT_W-1:0] expFault,
  input  logic [FAULT_W-1:0] storedFault,
  output logic [IDX_W-1:0]   rs1Idx,
  output logic [IDX_W-1:0]   rs2Idx,
  output logic [IDX_W-1:0]   rdIdx,
  output logic               rs1Vld,
  output logic               rs2Vld,
  output logic               rdVld,
  output logic               rs1Zero,
  output logic               rs2Zero,
  output logic               opDone,
  output logic               regErr,
  output logic               typeReject,
  output logic [FAULT_W-1:0] faultCode,
  output logic               wipeLo,
  output logic               wipeHi,
  output logic               bankLoOn,
  output logic               bankHiOn
);

  logic [OP_CNT-1:0][1:0]       sizeAll;
  logic [OP_CNT-1:0][IDX_W-1:0] idxMap;
  logic [OP_CNT-1:0]            usedMap;
  logic [OP_CNT-1:0]            illMap;
  logic [OP_CNT-1:0][IDX_W-1:0] idxQ;
  logic [OP_CNT-1:0]            vldQ;
  logic [1:0]                   zeroQ;
  logic [1:0]                   wipeQ;
  logic [1:0]                   bankOnQ;
  ctrlStrobe_t                  strobe;
  logic                         unusedInstr;

  assign unusedInstr = ^instr;

  assign sizeAll[OP_RS1] = rs1Size;
  assign sizeAll[OP_RS2] = rs2Size;
  assign sizeAll[OP_RD]  = rdSize;

  for (genvar g = 0; g < OP_CNT; g++) begin : g_op
    localparam int LSB = (g == OP_RS1) ? RS1_LSB : (g == OP_RS2) ? RS2_LSB : RD_LSB;
    fpRegDecode_opMap #(.FIELD_W(FIELD_W)) i_opMap (
      .field  (instr[LSB +: FIELD_W]),
      .size   (sizeAll[g]),
      .idx    (idxMap[g]),
      .used   (usedMap[g]),
      .illegal(illMap[g])
    );
  end

  fpRegDecode_ctrl #(.FAULT_W(FAULT_W)) i_ctrl (
    .reqValid   (reqValid),
    .expFault   (expFault),
    .storedFault(storedFault),
    .opIllegal  (illMap),
    .strobe     (strobe)
  );

  fpRegDecode_dp #(
    .IDX_W       (IDX_W),
    .FAULT_W     (FAULT_W),
    .ILLEGAL_CODE(ILLEGAL_CODE)
  ) i_dp (
    .clk        (clk),
    .rst_n      (rst_n),
    .strobe     (strobe),
    .idxIn      (idxMap),
    .usedIn     (usedMap),
    .storedFault(storedFault),
    .idxQ       (idxQ),
    .vldQ       (vldQ),
    .zeroQ      (zeroQ),
    .wipeQ      (wipeQ),
    .bankOnQ    (bankOnQ),
    .doneQ      (opDone),
    .errQ       (regErr),
    .rejQ       (typeReject),
    .faultQ     (faultCode)
  );

  assign rs1Idx   = idxQ[OP_RS1];
  assign rs2Idx   = idxQ[OP_RS2];
  assign rdIdx    = idxQ[OP_RD];
  assign rs1Vld   = vldQ[OP_RS1];
  assign rs2Vld   = vldQ[OP_RS2];
  assign rdVld    = vldQ[OP_RD];
  assign rs1Zero  = zeroQ[OP_RS1];
  assign rs2Zero  = zeroQ[OP_RS2];
  assign wipeLo   = wipeQ[0];
  assign wipeHi   = wipeQ[1];
  assign bankLoOn = bankOnQ[0];
  assign bankHiOn = bankOnQ[1];

endmodule

// File: tb/test_fpRegDecode.sv
module test_fpRegDecode;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reqValid = 1'b0;
  logic [31:0] instr = '0;
  logic [1:0]  rs1Size = '0, rs2Size = '0, rdSize = '0;
  logic [2:0]  expFault = '0, storedFault = '0;
  logic [5:0]  rs1Idx, rs2Idx, rdIdx;
  logic        rs1Vld, rs2Vld, rdVld, rs1Zero, rs2Zero;
  logic        opDone, regErr, typeReject, wipeLo, wipeHi, bankLoOn, bankHiOn;
  logic [2:0]  faultCode;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  // model state
  bit [1:0] bankM = '0;
  int       faultM = 0;

  always #4 clk = ~clk;  // 125 MHz

  fpRegDecode i_fpRegDecode (
    .clk(clk), .rst_n(rst_n), .reqValid(reqValid), .instr(instr),
    .rs1Size(rs1Size), .rs2Size(rs2Size), .rdSize(rdSize),
    .expFault(expFault), .storedFault(storedFault),
    .rs1Idx(rs1Idx), .rs2Idx(rs2Idx), .rdIdx(rdIdx),
    .rs1Vld(rs1Vld), .rs2Vld(rs2Vld), .rdVld(rdVld),
    .rs1Zero(rs1Zero), .rs2Zero(rs2Zero),
    .opDone(opDone), .regErr(regErr), .typeReject(typeReject),
    .faultCode(faultCode), .wipeLo(wipeLo), .wipeHi(wipeHi),
    .bankLoOn(bankLoOn), .bankHiOn(bankHiOn)
  );

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic bit [5:0] mapIdx(bit [4:0] f, bit [1:0] s);
    if (s == 2'd0) return 6'd0;
    if (s == 2'd1) return {1'b0, f};
    return {f[0], f[4:1], 1'b0};
  endfunction

  // one request, full model-based checking; junk bits around fields test R3
  task automatic doOp(bit [1:0] s1, bit [4:0] f1, bit [1:0] s2, bit [4:0] f2,
                      bit [1:0] sd, bit [4:0] fd, bit [2:0] ex, bit [2:0] st);
    bit ill, rej, acc, v1, v2, vd;
    bit [5:0] m1, m2, md;
    bit z1, z2, wl, wh;
    string r1, r2, rd;
    @(negedge clk);
    instr = {2'b11, fd, 6'h2A, f1, 9'h1AB, f2};
    rs1Size = s1; rs2Size = s2; rdSize = sd;
    expFault = ex; storedFault = st; reqValid = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
    ill = (s1 == 3 && f1[1]) || (s2 == 3 && f2[1]) || (sd == 3 && fd[1]);
    rej = (ex != st);
    acc = !rej && !ill;
    m1 = mapIdx(f1, s1); m2 = mapIdx(f2, s2); md = mapIdx(fd, sd);
    v1 = acc && s1 != 0; v2 = acc && s2 != 0; vd = acc && sd != 0;
    z1 = v1 && !bankM[m1[5]];
    z2 = v2 && !bankM[m2[5]];
    wl = vd && !md[5] && !bankM[0];
    wh = vd && md[5] && !bankM[1];
    if (rej) faultM = st; else if (ill) faultM = 6; else faultM = 0;
    r1 = (s1 == 0) ? "R4" : (s1 == 1) ? "R1 R3" : "R2 R3";
    r2 = (s2 == 0) ? "R4" : (s2 == 1) ? "R1 R3" : "R2 R3";
    rd = (sd == 0) ? "R4" : (sd == 1) ? "R1 R3" : "R2 R3";
    chk(r1, "rs1Idx", rs1Idx, v1 ? m1 : 0);
    chk(r2, "rs2Idx", rs2Idx, v2 ? m2 : 0);
    chk(rd, "rdIdx", rdIdx, vd ? md : 0);
    chk("R4 R5 R6", "rs1Vld", rs1Vld, v1);
    chk("R4 R5 R6", "rs2Vld", rs2Vld, v2);
    chk("R4 R5 R6", "rdVld", rdVld, vd);
    chk("R8 R12", "rs1Zero", rs1Zero, z1);
    chk("R8 R12", "rs2Zero", rs2Zero, z2);
    chk("R9 R4", "wipeLo", wipeLo, wl);
    chk("R9 R4", "wipeHi", wipeHi, wh);
    bankM[0] = bankM[0] | wl;
    bankM[1] = bankM[1] | wh;
    chk("R9 R5 R6", "bankLoOn", bankLoOn, bankM[0]);
    chk("R9 R5 R6", "bankHiOn", bankHiOn, bankM[1]);
    chk("R7", "opDone", opDone, acc);
    chk("R5", "regErr", regErr, ill && !rej);
    chk("R6", "typeReject", typeReject, rej);
    chk("R5 R6 R7", "faultCode", faultCode, faultM);
  endtask

  task automatic testReset();
    chk("R10", "bankLoOn", bankLoOn, 0);
    chk("R10", "bankHiOn", bankHiOn, 0);
    chk("R10", "strobes", {opDone, regErr, typeReject, wipeLo, wipeHi, rs1Vld, rs2Vld, rdVld}, 0);
    chk("R10", "faultCode", faultCode, 0);
  endtask

  task automatic testIdle();
    @(negedge clk);
    @(negedge clk);
    chk("R11", "idle strobes", {opDone, regErr, typeReject, wipeLo, wipeHi,
                                rs1Vld, rs2Vld, rdVld, rs1Zero, rs2Zero}, 0);
    chk("R11", "idle indexes", {rs1Idx, rs2Idx, rdIdx}, 0);
    chk("R11", "idle faultCode hold", faultCode, faultM);
  endtask

  // R6: mismatch, also with a misaligned quad present (reject must win)
  task automatic testMismatch();
    doOp(2'd1, 5'd3, 2'd1, 5'd4, 2'd1, 5'd5, 3'd3, 3'd2);
    doOp(2'd3, 5'd2, 2'd3, 5'd0, 2'd3, 5'd0, 3'd2, 3'd3);
  endtask

  // R5: misaligned quad in one slot only, banks still off
  task automatic testIllegal();
    doOp(2'd3, 5'd2, 2'd3, 5'd0, 2'd3, 5'd0, 3'd3, 3'd3);
    doOp(2'd3, 5'd0, 2'd3, 5'd31, 2'd3, 5'd4, 3'd3, 3'd3);
  endtask

  // R4: unused slots
  task automatic testUnused();
    doOp(2'd0, 5'd9, 2'd1, 5'd7, 2'd0, 5'd12, 3'd2, 3'd2);
  endtask

  // R1 R12: first write into lower bank with sources in same bank
  task automatic testSingleFirst();
    doOp(2'd1, 5'd17, 2'd1, 5'd31, 2'd1, 5'd5, 3'd2, 3'd2);
  endtask

  // R2 R9: double ops, upper bank enabled by first, not wiped by second
  task automatic testDouble();
    doOp(2'd2, 5'd4, 2'd2, 5'd9, 2'd2, 5'd3, 3'd2, 3'd2);
    doOp(2'd2, 5'd4, 2'd2, 5'd9, 2'd2, 5'd3, 3'd2, 3'd2);
  endtask

  // R2 R5: legal quad, then misaligned destination after banks on
  task automatic testQuad();
    doOp(2'd3, 5'd13, 2'd3, 5'd0, 2'd3, 5'd28, 3'd3, 3'd3);
    doOp(2'd3, 5'd13, 2'd3, 5'd0, 2'd3, 5'd6, 3'd3, 3'd3);
    doOp(2'd1, 5'd30, 2'd2, 5'd31, 2'd2, 5'd1, 3'd2, 3'd2);
  endtask

  initial begin
    #(8 * 20000);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    testReset();
    testMismatch();
    testIdle();
    testIllegal();
    testUnused();
    testSingleFirst();
    testIdle();
    testDouble();
    testQuad();
    testIdle();
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule